// File: doc/BRIEF.md
# Self-Correcting Add-Compare-Select Cell

This cell performs one trellis update for a convolutional-code decoder state: it adds a 4-bit branch metric to each of two incoming 8-bit path metrics, selects one survivor with a relaxed split comparison, and registers the updated metric together with the decision bit. Beside the full-width adder runs a cheap estimator. It builds a coarse replica of the updated metric from the chosen old metric and the chosen branch metric alone.

A decision stage compares the upper nibble of the adder result with the upper nibble of the replica. If the two differ by more than one step, taken modulo 16, the adder result is assumed to carry a timing fault. The replica then replaces it and an error flag is raised. Faults in the adder are expected in the upper bits only, because carries ripple upward from the least-significant bit. A test-only mask XORs a pattern onto the adder's upper nibble so that such faults can be produced on demand. Wrong survivor choices made by the relaxed comparison are accepted as they are and are not corrected.

Top module: `acs_ant_cell`

## Requirements
- R1: While `rst_n` is low, `pm_out`, `dec_out` and `err_out` are all zero.
- R2: When the upper nibbles of the two old metrics differ, the path with the smaller upper nibble is chosen. The comparison uses the mod-16 difference read as signed, so a difference of exactly -8 favours path A. `dec_out`=1 means path B.
- R3: When the upper nibbles are equal, the decision compares the 5-bit sums (low nibble + branch metric) of the two paths. Path B is chosen only if its sum is strictly smaller, so a tie keeps path A.
- R4: The estimate has as its upper nibble the upper nibble of the chosen old metric. Its low nibble is 4'hF when the chosen branch metric is 8 or more; otherwise it is the low nibble of the chosen old metric.
- R5: With `inj_mask`=0, `pm_out` equals the chosen old metric plus the chosen branch metric, modulo 256, and `err_out` is 0.
- R6: `err_out` is 1 exactly when the difference (adder upper nibble XOR mask) minus (estimate upper nibble), taken mod 16, is not 0, 1 or 15.
- R7: When `err_out` is 1, `pm_out` equals the full 8-bit estimate.
- R8: When the mask perturbs the adder but the difference stays within plus or minus one, `err_out` is 0 and `pm_out` is the perturbed adder result.
- R9: All outputs appear one clock after their inputs are sampled. `inj_mask` never changes `dec_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_a_in | input | 8 | Old path metric, path A |
| pm_b_in | input | 8 | Old path metric, path B |
| bm_a_in | input | 4 | Branch metric for path A |
| bm_b_in | input | 4 | Branch metric for path B |
| inj_mask | input | 4 | Test-only XOR mask on the adder's upper nibble |
| pm_out | output | 8 | Corrected updated path metric |
| dec_out | output | 1 | Survivor decision (1 = path B) |
| err_out | output | 1 | Adder error detected and replaced |

## Verification
The relaxed survivor choice and the adder-fault override can act on the same update. In that case the estimate has to be built from the path the relaxed comparison picked, and not from a full-precision choice. The bench provokes this by giving both metrics equal upper nibbles, so the decision falls to the low-sum comparison, and injecting a multi-step mask in the same cycle. Each outcome is judged against an independent model: the replaced metric must match the estimate of the selected path, and the decision bit must match the value it takes with a zero mask.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int PM_W  = 8;
  localparam int BM_W  = 4;
  localparam int NIB_W = PM_W / 2;
  localparam int LOW_W = NIB_W + 1;

  typedef logic [PM_W-1:0]  pm_t;
  typedef logic [BM_W-1:0]  bm_t;
  typedef logic [NIB_W-1:0] nib_t;

  function automatic nib_t hi_nib(input pm_t p);
    return p[PM_W-1:NIB_W];
  endfunction

  function automatic nib_t lo_nib(input pm_t p);
    return p[NIB_W-1:0];
  endfunction

  // Relaxed survivor choice: 1 selects path B.
  function automatic logic rcs_pick(input pm_t a, input pm_t b, input bm_t ba, input bm_t bb);
    nib_t gap;
    logic [LOW_W-1:0] sa;
    logic [LOW_W-1:0] sb;
    gap = hi_nib(a) - hi_nib(b);
    sa  = LOW_W'(lo_nib(a)) + LOW_W'(ba);
    sb  = LOW_W'(lo_nib(b)) + LOW_W'(bb);
    if (gap == '0) return (sb < sa);
    return (!gap[NIB_W-1]);
  endfunction

  function automatic pm_t coarse_est(input pm_t p, input bm_t bm);
    nib_t lo;
    lo = bm[BM_W-1] ? {NIB_W{1'b1}} : lo_nib(p);
    return {hi_nib(p), lo};
  endfunction

  function automatic logic gap_exceeds(input nib_t main_hi, input nib_t est_hi);
    nib_t d;
    d = main_hi - est_hi;
    return !((d == '0) || (d == nib_t'(1)) || (d == {NIB_W{1'b1}}));
  endfunction
endpackage

// File: rtl/acs_relaxed_cs.sv
module acs_relaxed_cs
  import acs_pkg::*;
(
  input  logic [1:0][PM_W-1:0] pm_pair,
  input  logic [1:0][BM_W-1:0] bm_pair,
  output logic                 pick,
  output logic [PM_W-1:0]      sel_pm,
  output logic [BM_W-1:0]      sel_bm
);
  always_comb begin
    pick   = rcs_pick(pm_pair[0], pm_pair[1], bm_pair[0], bm_pair[1]);
    sel_pm = pm_pair[pick];
    sel_bm = bm_pair[pick];
  end
endmodule

// File: rtl/acs_main_add.sv
module acs_main_add
  import acs_pkg::*;
#(
  parameter int NPATH = 2
) (
  input  logic [NPATH-1:0][PM_W-1:0] pm_pair,
  input  logic [NPATH-1:0][BM_W-1:0] bm_pair,
  input  logic [$clog2(NPATH)-1:0]   pick,
  input  logic [NIB_W-1:0]           inj_mask,
  output logic [PM_W-1:0]            main_metric
);
  logic [NPATH-1:0][PM_W-1:0] cand;

  for (genvar g = 0; g < NPATH; g++) begin : g_add
    assign cand[g] = pm_pair[g] + PM_W'(bm_pair[g]);
  end

  assign main_metric = cand[pick] ^ {inj_mask, {NIB_W{1'b0}}};
endmodule

// File: rtl/acs_estimator.sv
module acs_estimator
  import acs_pkg::*;
(
  input  logic [PM_W-1:0] sel_pm,
  input  logic [BM_W-1:0] sel_bm,
  output logic [PM_W-1:0] est_metric
);
  assign est_metric = coarse_est(sel_pm, sel_bm);
endmodule

// File: rtl/acs_ant_decide.sv
module acs_ant_decide
  import acs_pkg::*;
(
  input  logic [PM_W-1:0] main_metric,
  input  logic [PM_W-1:0] est_metric,
  output logic            err,
  output logic [PM_W-1:0] fixed_metric
);
  always_comb begin
    err          = gap_exceeds(hi_nib(main_metric), hi_nib(est_metric));
    fixed_metric = err ? est_metric : main_metric;
  end
endmodule

// File: rtl/acs_ant_cell.sv
module acs_ant_cell
  import acs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PM_W-1:0]  pm_a_in,
  input  logic [PM_W-1:0]  pm_b_in,
  input  logic [BM_W-1:0]  bm_a_in,
  input  logic [BM_W-1:0]  bm_b_in,
  input  logic [NIB_W-1:0] inj_mask,
  output logic [PM_W-1:0]  pm_out,
  output logic             dec_out,
  output logic             err_out
);
  logic [1:0][PM_W-1:0] pm_pair;
  logic [1:0][BM_W-1:0] bm_pair;
  logic                 pick_w;
  logic [PM_W-1:0]      sel_pm_w;
  logic [BM_W-1:0]      sel_bm_w;
  logic [PM_W-1:0]      main_w;
  logic [PM_W-1:0]      est_w;
  logic                 err_w;
  logic [PM_W-1:0]      fixed_w;

  assign pm_pair = {pm_b_in, pm_a_in};
  assign bm_pair = {bm_b_in, bm_a_in};

  acs_relaxed_cs u_rcs (
    .pm_pair(pm_pair), .bm_pair(bm_pair),
    .pick(pick_w), .sel_pm(sel_pm_w), .sel_bm(sel_bm_w)
  );

  acs_main_add #(.NPATH(2)) u_add (
    .pm_pair(pm_pair), .bm_pair(bm_pair), .pick(pick_w),
    .inj_mask(inj_mask), .main_metric(main_w)
  );

  acs_estimator u_est (
    .sel_pm(sel_pm_w), .sel_bm(sel_bm_w), .est_metric(est_w)
  );

  acs_ant_decide u_dec (
    .main_metric(main_w), .est_metric(est_w),
    .err(err_w), .fixed_metric(fixed_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_out  <= '0;
      dec_out <= 1'b0;
      err_out <= 1'b0;
    end else begin
      pm_out  <= fixed_w;
      dec_out <= pick_w;
      err_out <= err_w;
    end
  end
endmodule

// File: rtl/acs_ant_checker.sv
module acs_ant_checker
  import acs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pick_w,
  input logic             err_w,
  input logic [PM_W-1:0]  main_w,
  input logic [PM_W-1:0]  est_w,
  input logic [PM_W-1:0]  sel_pm_w,
  input logic [NIB_W-1:0] inj_mask,
  input logic [PM_W-1:0]  pm_out,
  input logic             dec_out,
  input logic             err_out
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_R1: assert (pm_out == '0 && !dec_out && !err_out);
    end
  end

  assert_est_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    est_w[PM_W-1:NIB_W] == sel_pm_w[PM_W-1:NIB_W]);

  assert_clean_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_mask == '0) |=> !err_out);

  assert_replace_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_w |=> (pm_out == $past(est_w)) && err_out);

  assert_keep_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_w |=> (pm_out == $past(main_w)) && !err_out);

  assert_dec_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dec_out == $past(pick_w));
endmodule

bind acs_ant_cell acs_ant_checker u_acs_ant_checker (
  .clk(clk), .rst_n(rst_n), .pick_w(pick_w), .err_w(err_w),
  .main_w(main_w), .est_w(est_w), .sel_pm_w(sel_pm_w),
  .inj_mask(inj_mask), .pm_out(pm_out), .dec_out(dec_out), .err_out(err_out)
);

// File: tb/test_acs_ant_cell.sv
module test_acs_ant_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pm_a_in = '0, pm_b_in = '0;
  logic [3:0] bm_a_in = '0, bm_b_in = '0, inj_mask = '0;
  logic [7:0] pm_out;
  logic       dec_out, err_out;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  acs_ant_cell i_acs_ant_cell (
    .clk(clk), .rst_n(rst_n), .pm_a_in(pm_a_in), .pm_b_in(pm_b_in),
    .bm_a_in(bm_a_in), .bm_b_in(bm_b_in), .inj_mask(inj_mask),
    .pm_out(pm_out), .dec_out(dec_out), .err_out(err_out)
  );

  // Independent integer model of the requirements.
  function automatic int m_dec(int a, int b, int ba, int bb);
    int dh;
    dh = ((a / 16) - (b / 16) + 16) % 16;
    if (dh == 0) return ((b % 16) + bb < (a % 16) + ba) ? 1 : 0;
    return (dh < 8) ? 1 : 0;
  endfunction

  function automatic int m_est(int a, int b, int ba, int bb);
    int p, q;
    p = m_dec(a, b, ba, bb) ? b : a;
    q = m_dec(a, b, ba, bb) ? bb : ba;
    return (p / 16) * 16 + ((q >= 8) ? 15 : p % 16);
  endfunction

  function automatic int m_main(int a, int b, int ba, int bb, int m);
    int s;
    s = m_dec(a, b, ba, bb) ? (b + bb) % 256 : (a + ba) % 256;
    return s ^ (m * 16);
  endfunction

  function automatic int m_flag(int a, int b, int ba, int bb, int m);
    int d;
    d = ((m_main(a, b, ba, bb, m) / 16) - (m_est(a, b, ba, bb) / 16) + 16) % 16;
    return (d == 0 || d == 1 || d == 15) ? 0 : 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(int a, int b, int ba, int bb, int m);
    @(negedge clk);
    pm_a_in = 8'(a); pm_b_in = 8'(b); bm_a_in = 4'(ba); bm_b_in = 4'(bb); inj_mask = 4'(m);
    @(negedge clk);
  endtask

  task automatic full_check(string req, int a, int b, int ba, int bb, int m);
    drive(a, b, ba, bb, m);
    chk({req, " dec"}, dec_out, m_dec(a, b, ba, bb));
    chk({req, " flag"}, err_out, m_flag(a, b, ba, bb, m));
    chk({req, " metric"}, pm_out,
        m_flag(a, b, ba, bb, m) ? m_est(a, b, ba, bb) : m_main(a, b, ba, bb, m));
  endtask

  task automatic t_reset;
    pm_a_in = 8'h35; bm_a_in = 4'h7;
    #2;
    chk("R1 pm_out", pm_out, 0);
    chk("R1 dec_out", dec_out, 0);
    chk("R1 err_out", err_out, 0);
  endtask

  task automatic t_upper_decision;
    drive(8'h52, 8'h31, 0, 0, 0); chk("R2 B smaller upper", dec_out, 1);
    drive(8'h21, 8'h6F, 9, 0, 0); chk("R2 A smaller upper", dec_out, 0);
    drive(8'h10, 8'h90, 0, 0, 0); chk("R2 gap -8 keeps A", dec_out, 0);
    drive(8'hF0, 8'h10, 0, 0, 0); chk("R2 wraparound picks A", dec_out, 0);
  endtask

  task automatic t_lower_decision;
    drive(8'h43, 8'h45, 5, 2, 0); chk("R3 B lower sum", dec_out, 1);
    drive(8'h43, 8'h45, 4, 2, 0); chk("R3 tie keeps A", dec_out, 0);
    drive(8'h4F, 8'h40, 15, 0, 0); chk("R3 carry bit counts", dec_out, 1);
  endtask

  task automatic t_clean;
    drive(8'h10, 8'h80, 3, 4, 0);
    chk("R5 metric", pm_out, 8'h13); chk("R5 flag", err_out, 0);
    drive(8'hFA, 8'hF9, 9, 12, 0);
    chk("R5 wrap metric", pm_out, 8'h03); chk("R5 wrap flag", err_out, 0);
    for (int i = 0; i < 40; i++)
      full_check("R5 sweep", (i * 37) % 256, (i * 91 + 5) % 256, i % 16, (i * 7) % 16, 0);
  endtask

  task automatic t_inject_big;
    // chosen A=0x36, bm 9: estimate 0x3F, main 0x3F ^ 0x40 = 0x7F
    drive(8'h36, 8'h90, 9, 0, 4);
    chk("R6 flag", err_out, 1); chk("R7 metric est bm>=8", pm_out, 8'h3F);
    chk("R4 est low ones", pm_out % 16, 15);
    drive(8'h36, 8'h90, 5, 0, 8);
    chk("R6 flag", err_out, 1); chk("R4 est low kept", pm_out, 8'h36);
    for (int m = 1; m < 16; m++) full_check("R6 mask sweep", 8'h7E, 8'hC0, 3, 1, m);
  endtask

  task automatic t_inject_small;
    // main 0x25 ^ 0x10 = 0x35, est hi 2: diff +1 passes
    drive(8'h23, 8'hA0, 2, 0, 1);
    chk("R8 flag", err_out, 0); chk("R8 corrupted main kept", pm_out, 8'h35);
  endtask

  task automatic t_same_cycle;
    // Equal upper nibbles: low-sum decision picks B, plus big fault
    drive(8'h5C, 8'h54, 2, 1, 6);
    chk("R3 dec under fault", dec_out, 1);
    chk("R6 flag under relaxed pick", err_out, 1);
    chk("R7 estimate of chosen B", pm_out, 8'h54);
  endtask

  task automatic t_latency;
    @(negedge clk);
    pm_a_in = 8'h80; pm_b_in = 8'h20; bm_a_in = 0; bm_b_in = 3; inj_mask = 0;
    #1 chk("R9 old value held", pm_out, 8'h54);
    @(negedge clk);
    chk("R9 one cycle later", pm_out, 8'h23);
    drive(8'h80, 8'h20, 0, 3, 15);
    chk("R9 mask leaves dec", dec_out, 1);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_upper_decision();
    t_lower_decision();
    t_clean();
    t_inject_big();
    t_inject_small();
    t_same_cycle();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule